// File: doc/BRIEF.md
# Interrupt Priority Claim Arbiter

This block is the decision core of a level-sensitive interrupt controller serving several contexts (a context is one processor privilege level that takes interrupts). It holds a pending bit and an in-service (claimed) bit for every source, a priority for every source, and an enable mask and a threshold for every context. For each context a registered priority scan picks the best source that is pending, not in service and enabled. That source must also have a priority strictly above the context threshold. The scan drives the context's interrupt line and its best-ID output.

Software-facing logic outside this block turns bus accesses into three kinds of request. A configuration write sets one source priority, one context threshold, or one 32-bit word of a context enable mask. A claim strobe takes the current winner of a context and marks it in service. A complete strobe, carrying a source ID, releases that source. Source 0 is reserved to mean "no interrupt". The source count includes it.

Top module: `irq_claim_core`

## Requirements
- R1: A source is a candidate for a context only if its pending bit is set, its claimed bit is clear, and its enable bit for that context is set.
- R2: The winner's priority must be strictly greater than the context threshold. A source whose priority equals the threshold never wins.
- R3: Among candidates of equal priority, the lowest source ID wins.
- R4: `best_id_o` for a context is 0 when no candidate qualifies. `irq_o` for the context is high exactly when its `best_id_o` is nonzero. Both are registered and reflect the state from one cycle earlier.
- R5: Each cycle, the pending bit of source k copies `src_i[k]`, with no edge latching. Source 0 is never pending.
- R6: While `claim_i[c]` is high, `claim_id_o` for context c returns the registered winner, provided that source is not already claimed. Otherwise it returns 0. A nonzero return clears that source's pending bit and sets its claimed bit at the next edge. When `claim_i[c]` is low, `claim_id_o` for context c is 0.
- R7: A complete clears the claimed bit of its ID only when the ID is below NSRC. Otherwise it has no effect. When a claim and a complete of the same ID land in the same cycle, the claim wins.
- R8: When several contexts claim the same source in one cycle, the lowest-indexed context receives it and the others receive 0.
- R9: `cfg_sel_i` selects the target of a configuration write: 0 = source priority `cfg_idx_i`, 1 = threshold of context `cfg_ctx_i`, 2 = enable word `cfg_idx_i` of context `cfg_ctx_i`, 3 = nothing. Priorities and thresholds keep the low PRIO_W bits of `cfg_data_i`. In enable word w, bit b controls source 32*w+b. Bits for sources at or above NSRC are dropped.
- R10: A synchronous active-high reset clears all priorities, thresholds, enables, pending and claimed bits, and drives every `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Source interrupt levels (bit 0 unused) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 priority, 1 threshold, 2 enable word |
| cfg_ctx_i | input | CTX_W | Context addressed by a threshold or enable write |
| cfg_idx_i | input | ID_W | Source index (priority) or enable word index |
| cfg_data_i | input | 32 | Write data |
| claim_i | input | NCTX | Per-context claim strobe |
| cmpl_i | input | NCTX | Per-context complete strobe |
| cmpl_id_i | input | NCTX*ID_W | Per-context ID released by a complete |
| irq_o | output | NCTX | Per-context interrupt line |
| best_id_o | output | NCTX*ID_W | Per-context registered winner, 0 if none |
| claim_id_o | output | NCTX*ID_W | Per-context ID returned by a claim in this cycle |

## Verification
The assertions assume that `cfg_ctx_i` names an existing context and that the requester drives the strobes only while out of reset. The bench keeps to this by holding every strobe low during reset and drawing context numbers only from 0 to NCTX-1. Complete IDs are drawn across the full ID_W range, so out-of-range releases are exercised. Claims are issued blindly, including on a winner that another context has just taken. This stresses the stale-winner rejection that the uniqueness and claim-set assertions rely on.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        CFG_PRIO   = 2'd0,
        CFG_THRESH = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    localparam int unsigned WORD_BITS = 32;

    function automatic int unsigned words_for(input int unsigned n);
        return (n + WORD_BITS - 1) / WORD_BITS;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6,
    parameter int CTX_W  = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  cfg_sel_e               sel_i,
    input  logic [CTX_W-1:0]       ctx_i,
    input  logic [ID_W-1:0]        idx_i,
    input  logic [31:0]            data_i,
    output logic [NSRC*PRIO_W-1:0] prio_o,
    output logic [NCTX*PRIO_W-1:0] thr_o,
    output logic [NCTX*NSRC-1:0]   en_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_o <= '0;
            thr_o  <= '0;
            en_o   <= '0;
        end else if (we_i) begin
            case (sel_i)
                CFG_PRIO: begin
                    for (int k = 0; k < NSRC; k++) begin
                        if (int'(idx_i) == k) prio_o[k*PRIO_W +: PRIO_W] <= data_i[PRIO_W-1:0];
                    end
                end
                CFG_THRESH: begin
                    for (int c = 0; c < NCTX; c++) begin
                        if (int'(ctx_i) == c) thr_o[c*PRIO_W +: PRIO_W] <= data_i[PRIO_W-1:0];
                    end
                end
                CFG_ENABLE: begin
                    for (int c = 0; c < NCTX; c++) begin
                        for (int k = 0; k < NSRC; k++) begin
                            if (int'(ctx_i) == c && int'(idx_i) == k / WORD_BITS)
                                en_o[c*NSRC + k] <= data_i[k % WORD_BITS];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_src_state.sv
module irq_src_state #(
    parameter int NSRC = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] claim_mask_i,
    input  logic [NSRC-1:0] cmpl_mask_i,
    output logic [NSRC-1:0] pending_q,
    output logic [NSRC-1:0] claimed_q
);

    logic [NSRC-1:0] pending_d;

    always_comb begin
        pending_d    = src_i & ~claim_mask_i;
        pending_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            claimed_q <= '0;
        end else begin
            pending_q <= pending_d;
            claimed_q <= (claimed_q & ~cmpl_mask_i) | claim_mask_i;
        end
    end

    // R6
    claim_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_mask_i != '0) |=> ((claimed_q & $past(claim_mask_i)) == $past(claim_mask_i)));

    // R7
    claimed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_mask_i == '0 && cmpl_mask_i == '0) |=> $stable(claimed_q));

endmodule

// File: rtl/irq_ctx_arb.sv
module irq_ctx_arb #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thr_i,
    input  logic [NSRC-1:0]        en_i,
    input  logic [NSRC-1:0]        pending_i,
    input  logic [NSRC-1:0]        claimed_i,
    output logic [ID_W-1:0]        best_q,
    output logic                   irq_q
);

    logic [NSRC-1:0]   cand;
    logic [ID_W-1:0]   best_d;
    logic [PRIO_W-1:0] best_p;

    assign cand = pending_i & ~claimed_i & en_i;

    // Strict comparison: a later source replaces only on a higher priority.
    always_comb begin
        best_d = '0;
        best_p = thr_i;
        for (int k = 1; k < NSRC; k++) begin
            if (cand[k] && prio_i[k*PRIO_W +: PRIO_W] > best_p) begin
                best_p = prio_i[k*PRIO_W +: PRIO_W];
                best_d = ID_W'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            best_q <= best_d;
            irq_q  <= (best_d != '0);
        end
    end

    // R2
    always_ff @(posedge clk) begin
        if (!rst && best_d != '0)
            win_above_thr_chk: assert (prio_i[int'(best_d)*PRIO_W +: PRIO_W] > thr_i);
    end

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (best_d != '0) |=> (irq_q && best_q != '0));

    // R4
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (best_d == '0) |=> (!irq_q && best_q == '0));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !irq_q);

endmodule

// File: rtl/irq_claim_grant.sv
module irq_claim_grant #(
    parameter int NSRC = 40,
    parameter int NCTX = 2,
    parameter int ID_W = 6
) (
    input  logic                 rst,
    input  logic [NCTX*ID_W-1:0] best_i,
    input  logic [NSRC-1:0]      claimed_i,
    input  logic [NCTX-1:0]      claim_i,
    input  logic [NCTX-1:0]      cmpl_i,
    input  logic [NCTX*ID_W-1:0] cmpl_id_i,
    output logic [NCTX*ID_W-1:0] grant_o,
    output logic [NSRC-1:0]      claim_mask_o,
    output logic [NSRC-1:0]      cmpl_mask_o
);

    // Contexts are visited in index order, so the lowest one wins a shared source.
    always_comb begin
        logic [ID_W-1:0] id;
        logic [ID_W-1:0] cid;
        grant_o      = '0;
        claim_mask_o = '0;
        cmpl_mask_o  = '0;
        for (int c = 0; c < NCTX; c++) begin
            id  = best_i[c*ID_W +: ID_W];
            cid = cmpl_id_i[c*ID_W +: ID_W];
            if (claim_i[c] && id != '0 && int'(id) < NSRC) begin
                if (!claimed_i[id] && !claim_mask_o[id]) begin
                    grant_o[c*ID_W +: ID_W] = id;
                    claim_mask_o[id]        = 1'b1;
                end
            end
            if (cmpl_i[c] && int'(cid) < NSRC)
                cmpl_mask_o[cid] = 1'b1;
        end
    end

    // R8
    always_comb begin
        if (!rst) begin
            for (int a = 0; a < NCTX; a++) begin
                for (int b = a + 1; b < NCTX; b++) begin
                    if (grant_o[a*ID_W +: ID_W] != '0)
                        grant_unique_chk: assert (grant_o[a*ID_W +: ID_W] != grant_o[b*ID_W +: ID_W]);
                end
            end
        end
    end

endmodule

// File: rtl/irq_claim_core.sv
module irq_claim_core
    import irq_arb_pkg::*;
#(
    parameter  int NSRC   = 40,
    parameter  int NCTX   = 2,
    parameter  int PRIO_W = 3,
    localparam int ID_W   = $clog2(NSRC),
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_i,
    input  logic                 cfg_we_i,
    input  logic [1:0]           cfg_sel_i,
    input  logic [CTX_W-1:0]     cfg_ctx_i,
    input  logic [ID_W-1:0]      cfg_idx_i,
    input  logic [31:0]          cfg_data_i,
    input  logic [NCTX-1:0]      claim_i,
    input  logic [NCTX-1:0]      cmpl_i,
    input  logic [NCTX*ID_W-1:0] cmpl_id_i,
    output logic [NCTX-1:0]      irq_o,
    output logic [NCTX*ID_W-1:0] best_id_o,
    output logic [NCTX*ID_W-1:0] claim_id_o
);

    localparam int NWORDS = int'(words_for(NSRC));

    logic [NSRC*PRIO_W-1:0] prio;
    logic [NCTX*PRIO_W-1:0] thr;
    logic [NCTX*NSRC-1:0]   en;
    logic [NSRC-1:0]        pending;
    logic [NSRC-1:0]        claimed;
    logic [NSRC-1:0]        claim_mask;
    logic [NSRC-1:0]        cmpl_mask;

    initial begin
        if (NWORDS > (1 << ID_W)) $error("enable word index does not fit cfg_idx_i");
    end

    irq_cfg_regs #(
        .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ID_W(ID_W), .CTX_W(CTX_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we_i(cfg_we_i), .sel_i(cfg_sel_e'(cfg_sel_i)),
        .ctx_i(cfg_ctx_i), .idx_i(cfg_idx_i), .data_i(cfg_data_i),
        .prio_o(prio), .thr_o(thr), .en_o(en)
    );

    irq_src_state #(.NSRC(NSRC)) u_state (
        .clk(clk), .rst(rst), .src_i(src_i),
        .claim_mask_i(claim_mask), .cmpl_mask_i(cmpl_mask),
        .pending_q(pending), .claimed_q(claimed)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irq_ctx_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .clk(clk), .rst(rst), .prio_i(prio),
            .thr_i(thr[c*PRIO_W +: PRIO_W]), .en_i(en[c*NSRC +: NSRC]),
            .pending_i(pending), .claimed_i(claimed),
            .best_q(best_id_o[c*ID_W +: ID_W]), .irq_q(irq_o[c])
        );
    end

    irq_claim_grant #(.NSRC(NSRC), .NCTX(NCTX), .ID_W(ID_W)) u_grant (
        .rst(rst), .best_i(best_id_o), .claimed_i(claimed),
        .claim_i(claim_i), .cmpl_i(cmpl_i), .cmpl_id_i(cmpl_id_i),
        .grant_o(claim_id_o), .claim_mask_o(claim_mask), .cmpl_mask_o(cmpl_mask)
    );

endmodule

// File: tb/irq_claim_core_bench.sv
module irq_claim_core_bench;

    localparam int NSRC   = 40;
    localparam int NCTX   = 2;
    localparam int PRIO_W = 3;
    localparam int ID_W   = $clog2(NSRC);
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;
    localparam int PMASK  = (1 << PRIO_W) - 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSRC-1:0]      src = '0;
    logic                 cfg_we = 1'b0;
    logic [1:0]           cfg_sel = '0;
    logic [CTX_W-1:0]     cfg_ctx = '0;
    logic [ID_W-1:0]      cfg_idx = '0;
    logic [31:0]          cfg_data = '0;
    logic [NCTX-1:0]      claim = '0;
    logic [NCTX-1:0]      cmpl = '0;
    logic [NCTX*ID_W-1:0] cmpl_id = '0;
    logic [NCTX-1:0]      irq;
    logic [NCTX*ID_W-1:0] best_id;
    logic [NCTX*ID_W-1:0] claim_id;

    always #2 clk = ~clk;

    irq_claim_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_irq_claim_core (
        .clk(clk), .rst(rst), .src_i(src), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_ctx_i(cfg_ctx), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
        .claim_i(claim), .cmpl_i(cmpl), .cmpl_id_i(cmpl_id),
        .irq_o(irq), .best_id_o(best_id), .claim_id_o(claim_id)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural reference state
    int mprio[NSRC];
    int mthr[NCTX];
    bit men[NCTX][NSRC];
    bit mpend[NSRC];
    bit mclm[NSRC];
    int mbest[NCTX];
    int last_claim[NCTX];

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mscan(input int c);
        int b = 0;
        int bp = mthr[c];
        for (int k = 1; k < NSRC; k++) begin
            if (mpend[k] && !mclm[k] && men[c][k] && mprio[k] > bp) begin
                bp = mprio[k];
                b  = k;
            end
        end
        return b;
    endfunction

    // Inputs are set after a falling edge; this task checks, advances one clock, and checks again.
    task automatic tick();
        int  g[NCTX];
        int  nb[NCTX];
        bit  taken[NSRC];
        bit  cl[NSRC];
        #1;
        for (int k = 0; k < NSRC; k++) begin taken[k] = 0; cl[k] = 0; end
        for (int c = 0; c < NCTX; c++) begin
            int id = mbest[c];
            int cid = int'(cmpl_id[c*ID_W +: ID_W]);
            g[c] = 0;
            if (claim[c] && id != 0 && !mclm[id] && !taken[id]) begin
                g[c] = id;
                taken[id] = 1;
            end
            last_claim[c] = int'(claim_id[c*ID_W +: ID_W]);
            chk("R6/R8 claim_id", last_claim[c], g[c]);
            if (cmpl[c] && cid < NSRC) cl[cid] = 1;
        end
        for (int c = 0; c < NCTX; c++) nb[c] = mscan(c);
        if (rst) begin
            for (int k = 0; k < NSRC; k++) begin
                mprio[k] = 0; mpend[k] = 0; mclm[k] = 0;
                for (int c = 0; c < NCTX; c++) men[c][k] = 0;
            end
            for (int c = 0; c < NCTX; c++) begin mthr[c] = 0; nb[c] = 0; end
        end else begin
            if (cfg_we) begin
                case (int'(cfg_sel))
                    0: if (int'(cfg_idx) < NSRC) mprio[int'(cfg_idx)] = int'(cfg_data) & PMASK;
                    1: if (int'(cfg_ctx) < NCTX) mthr[int'(cfg_ctx)] = int'(cfg_data) & PMASK;
                    2: for (int k = 0; k < NSRC; k++)
                           if (k / 32 == int'(cfg_idx) && int'(cfg_ctx) < NCTX)
                               men[int'(cfg_ctx)][k] = cfg_data[k % 32];
                    default: ;
                endcase
            end
            for (int k = 0; k < NSRC; k++) begin
                mpend[k] = (k != 0) && src[k] && !taken[k];
                mclm[k]  = (mclm[k] && !cl[k]) || taken[k];
            end
        end
        for (int c = 0; c < NCTX; c++) mbest[c] = nb[c];
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCTX; c++) begin
            chk("R4 irq", int'(irq[c]), int'(mbest[c] != 0));
            chk("R1/R2/R3 best_id", int'(best_id[c*ID_W +: ID_W]), mbest[c]);
        end
        cfg_we = 1'b0;
        claim  = '0;
        cmpl   = '0;
    endtask

    task automatic wcfg(input int sel, input int ctx, input int idx, input int data);
        cfg_we   = 1'b1;
        cfg_sel  = 2'(sel);
        cfg_ctx  = CTX_W'(ctx);
        cfg_idx  = ID_W'(idx);
        cfg_data = 32'(data);
        tick();
    endtask

    function automatic int bid(input int c);
        return int'(best_id[c*ID_W +: ID_W]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        // R10: outputs quiet after reset
        chk("R10 irq after reset", int'(irq), 0);
        chk("R10 best after reset", int'(best_id), 0);
        tick();

        // R9: priorities keep the low bits only (0xF9 -> 1)
        wcfg(0, 0, 3, 5);
        wcfg(0, 0, 7, 5);
        wcfg(0, 0, 12, 2);
        wcfg(0, 0, 35, 6);
        wcfg(0, 0, 20, 'hF9);
        wcfg(2, 0, 0, 'hFFFF_FFFF);
        wcfg(2, 1, 0, 'h0000_1080);
        wcfg(1, 1, 0, 2);
        src[3] = 1'b1; src[7] = 1'b1; src[12] = 1'b1; src[35] = 1'b1; src[0] = 1'b1;
        tick();
        tick();
        chk("R3 tie to lowest id", bid(0), 3);
        chk("R2 equal threshold loses", bid(1), 7);

        // R9: second enable word, bits above the source count dropped
        wcfg(2, 0, 1, 'hFFFF_FFFF);
        tick();
        chk("R9 enable word 1", bid(0), 35);

        // R6: claim returns the winner, then a stale repeat returns 0
        claim[0] = 1'b1; tick();
        chk("R6 claim returns winner", last_claim[0], 35);
        claim[0] = 1'b1; tick();
        chk("R6 stale claim returns 0", last_claim[0], 0);
        chk("R6 next winner", bid(0), 3);
        claim[0] = 1'b1; tick();
        chk("R6 claim second", last_claim[0], 3);
        tick();
        chk("R1 claimed excluded", bid(0), 7);

        // R8: both contexts claim source 7 together
        claim = 2'b11; tick();
        chk("R8 low context served", last_claim[0], 7);
        chk("R8 high context refused", last_claim[1], 0);
        tick();
        chk("R8 ctx0 next", bid(0), 12);
        chk("R2 ctx1 nothing above threshold", int'(irq[1]), 0);

        // R7: out-of-range complete has no effect, valid one releases
        cmpl[0] = 1'b1; cmpl_id[0 +: ID_W] = ID_W'(50); tick();
        tick();
        chk("R7 out-of-range complete ignored", bid(0), 12);
        cmpl[0] = 1'b1; cmpl_id[0 +: ID_W] = ID_W'(3); tick();
        tick();
        chk("R7 complete releases", bid(0), 3);

        // R5: dropping the level removes the source
        src[3] = 1'b0; tick(); tick();
        chk("R5 level low clears pending", bid(0), 12);

        // Mixed stimulus against the reference model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                cfg_we   = 1'b1;
                cfg_sel  = 2'($urandom_range(0, 3));
                cfg_ctx  = CTX_W'($urandom_range(0, NCTX - 1));
                cfg_idx  = (cfg_sel == 2'd2) ? ID_W'($urandom_range(0, 2)) : ID_W'($urandom_range(0, NSRC - 1));
                cfg_data = $urandom;
            end
            if ($urandom_range(0, 2) == 0) src[$urandom_range(0, NSRC - 1)] ^= 1'b1;
            claim = NCTX'($urandom);
            cmpl  = NCTX'($urandom) & NCTX'($urandom);
            for (int c = 0; c < NCTX; c++)
                cmpl_id[c*ID_W +: ID_W] = ($urandom_range(0, 1) == 0) ? ID_W'($urandom) : best_id[c*ID_W +: ID_W];
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule